// File: doc/BRIEF.md
# Configurable Dedicated Input Cell

This cell conditions a single dedicated input pad before the signal enters the routing fabric. A two-bit mode field picks how the pad reaches the fabric. It can pass straight through. It can go through a transparent latch. It can be captured by one flip-flop, or by two flip-flops in series that act as a synchronizer for asynchronous inputs. Latching and capture use one clock, which the cell picks from a small set of system clocks, either two or four as a parameter sets. Each system clock has its own inversion bit, so the cell can capture on the rising or the falling edge of the chosen clock.

The cell also has an input/clock variant, chosen by a parameter. In that variant the pad is driven, through its own programmable inversion, onto a clock line that feeds the clocking of the surrounding cells. The fabric output and the clock line are single wires that have no flow control: the cell has no valid/ready handshake and applies no back-pressure, and every value is presented as soon as it is produced. The mode, the clock select and the inversion bits are static configuration. They may change only while the active-low reset is asserted, so that the capture clock never glitches while state is live.

Top module: `din_cond_cell`

## Requirements
- R1: With cap_mode_i = 0 (pass-through), fab_o follows pad_i combinationally at all times, including while reset is asserted.
- R2: With cap_mode_i = 1 (latch), fab_o follows pad_i while the effective capture clock is low.
- R3: With cap_mode_i = 1, fab_o holds the value pad_i had at the rising edge of the effective capture clock for as long as that clock stays high, whatever pad_i does.
- R4: With cap_mode_i = 2 (single register), fab_o takes the value of pad_i at each rising edge of the effective capture clock and holds it until the next one.
- R5: With cap_mode_i = 3 (double register), two flip-flops on the same capture clock lie in series, so after each rising edge fab_o shows the pad value sampled one edge earlier.
- R6: cap_sel_i (index k, 0 to NUM_SYSCLK-1, where NUM_SYSCLK is 2 or 4) makes sysclk_i[k] the capture clock, and the other system clocks have no effect on fab_o.
- R7: The effective capture clock is sysclk_i[k] XOR sysclk_inv_i[k]. Setting bit k therefore moves capture to the falling edge of sysclk_i[k] and inverts the latch's transparent phase.
- R8: While rst_ni is low, the latch and both flip-flops are cleared, so fab_o is 0 in modes 1, 2 and 3 whatever pad_i and the clocks do.
- R9: When IS_CLK_PIN = 1, gclk_o equals pad_i XOR pad_inv_i. When IS_CLK_PIN = 0, gclk_o is tied to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_ni | input | 1 | Asynchronous active-low reset of the capture state |
| sysclk_i | input | NUM_SYSCLK | System clocks available for capture |
| sysclk_inv_i | input | NUM_SYSCLK | Per-clock inversion bits (1 = falling edge active) |
| cap_sel_i | input | SEL_W | Index of the capture clock |
| cap_mode_i | input | 2 | 0 pass, 1 latch, 2 one register, 3 two registers |
| pad_i | input | 1 | Dedicated input pad |
| pad_inv_i | input | 1 | Inversion of the pad onto the clock line |
| fab_o | output | 1 | Conditioned signal to the interconnect |
| gclk_o | output | 1 | Clock line driven by the pad (input/clock variant) |

## Verification
The hard case is the latch hold phase under a clock that is both inverted and not the first clock. The pad must change while the latch is closed, and a wrong phase or a wrong clock pick has to show up at the output. The bench keeps its own model of the effective capture clock, built from the select and inversion it programmed. It writes each pattern bit just after that clock falls and writes the bit's complement just after it rises. Each half-phase therefore separates pass-through, latch, single-register and double-register behaviour, and a capture on the wrong clock or the wrong edge gives a different value.

// File: rtl/din_pkg.sv
package din_pkg;

  typedef enum logic [1:0] {
    CAP_PASS  = 2'd0,
    CAP_LATCH = 2'd1,
    CAP_REG1  = 2'd2,
    CAP_REG2  = 2'd3
  } cap_mode_e;

endpackage

// File: rtl/din_clk_pick.sv
module din_clk_pick #(
  parameter int NUM_SYSCLK = 4,
  localparam int SEL_W = (NUM_SYSCLK > 1) ? $clog2(NUM_SYSCLK) : 1
) (
  input  logic [NUM_SYSCLK-1:0] sysclk_i,
  input  logic [NUM_SYSCLK-1:0] sysclk_inv_i,
  input  logic [SEL_W-1:0]      sel_i,
  output logic                  cap_clk_o
);

  logic [NUM_SYSCLK-1:0] adj_clk;

  // one polarity mux per system clock
  for (genvar k = 0; k < NUM_SYSCLK; k++) begin : g_pol
    assign adj_clk[k] = sysclk_i[k] ^ sysclk_inv_i[k];
  end

  assign cap_clk_o = adj_clk[sel_i];

endmodule

// File: rtl/din_capture.sv
module din_capture
  import din_pkg::*;
(
  input  logic      rst_ni,
  input  logic      cap_clk_i,
  input  cap_mode_e mode_i,
  input  logic      pad_i,
  output logic      fab_o
);

  logic lat_q;
  logic stg1_q;
  logic stg2_q;

  // transparent while the capture clock is low
  always_latch begin
    if (!rst_ni)         lat_q <= 1'b0;
    else if (!cap_clk_i) lat_q <= pad_i;
  end

  // two-stage synchronizer on the same capture clock
  always_ff @(posedge cap_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg1_q <= 1'b0;
      stg2_q <= 1'b0;
    end else begin
      stg1_q <= pad_i;
      stg2_q <= stg1_q;
    end
  end

  always_comb begin
    unique case (mode_i)
      CAP_PASS:  fab_o = pad_i;
      CAP_LATCH: fab_o = lat_q;
      CAP_REG1:  fab_o = stg1_q;
      CAP_REG2:  fab_o = stg2_q;
      default:   fab_o = pad_i;
    endcase
  end

endmodule

// File: rtl/din_clk_line.sv
module din_clk_line #(
  parameter bit ENABLE = 1'b1
) (
  input  logic pad_i,
  input  logic pad_inv_i,
  output logic gclk_o
);

  if (ENABLE) begin : g_drive
    assign gclk_o = pad_i ^ pad_inv_i;
  end else begin : g_tie
    assign gclk_o = 1'b0;
  end

endmodule

// File: rtl/din_cond_cell.sv
module din_cond_cell
  import din_pkg::*;
#(
  parameter int NUM_SYSCLK = 4,
  parameter bit IS_CLK_PIN = 1'b1,
  localparam int SEL_W = (NUM_SYSCLK > 1) ? $clog2(NUM_SYSCLK) : 1
) (
  input  logic                  rst_ni,
  input  logic [NUM_SYSCLK-1:0] sysclk_i,
  input  logic [NUM_SYSCLK-1:0] sysclk_inv_i,
  input  logic [SEL_W-1:0]      cap_sel_i,
  input  logic [1:0]            cap_mode_i,
  input  logic                  pad_i,
  input  logic                  pad_inv_i,
  output logic                  fab_o,
  output logic                  gclk_o
);

  logic      cap_clk;
  cap_mode_e mode;

  assign mode = cap_mode_e'(cap_mode_i);

  din_clk_pick #(.NUM_SYSCLK(NUM_SYSCLK)) u_pick (
    .sysclk_i     (sysclk_i),
    .sysclk_inv_i (sysclk_inv_i),
    .sel_i        (cap_sel_i),
    .cap_clk_o    (cap_clk)
  );

  din_capture u_cap (
    .rst_ni    (rst_ni),
    .cap_clk_i (cap_clk),
    .mode_i    (mode),
    .pad_i     (pad_i),
    .fab_o     (fab_o)
  );

  din_clk_line #(.ENABLE(IS_CLK_PIN)) u_line (
    .pad_i     (pad_i),
    .pad_inv_i (pad_inv_i),
    .gclk_o    (gclk_o)
  );

endmodule

// File: rtl/din_cond_cell_chk.sv
module din_cond_cell_chk (
  input logic       rst_ni,
  input logic       cap_clk,
  input logic [1:0] cap_mode_i,
  input logic       pad_i,
  input logic       fab_o
);

  logic [1:0] seen_q;
  logic       held_q;

  // capture edges since reset, saturating at two
  always_ff @(posedge cap_clk or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 2'd0;
      held_q <= 1'b0;
    end else begin
      if (seen_q != 2'd2) seen_q <= seen_q + 2'd1;
      held_q <= pad_i;
    end
  end

  AST_LATCH_OPEN: assert property (@(posedge cap_clk) disable iff (!rst_ni)
    (cap_mode_i == 2'd1 && seen_q != 2'd0) |-> fab_o == pad_i); // R2

  AST_LATCH_HOLD: assert property (@(negedge cap_clk) disable iff (!rst_ni)
    (cap_mode_i == 2'd1 && seen_q != 2'd0) |-> fab_o == held_q); // R3

  AST_REG1_DELAY: assert property (@(posedge cap_clk) disable iff (!rst_ni)
    (cap_mode_i == 2'd2 && seen_q != 2'd0) |-> fab_o == $past(pad_i)); // R4

  AST_REG2_DELAY: assert property (@(posedge cap_clk) disable iff (!rst_ni)
    (cap_mode_i == 2'd3 && seen_q == 2'd2) |-> fab_o == $past(pad_i, 2)); // R5

endmodule

bind din_cond_cell din_cond_cell_chk u_chk (
  .rst_ni     (rst_ni),
  .cap_clk    (cap_clk),
  .cap_mode_i (cap_mode_i),
  .pad_i      (pad_i),
  .fab_o      (fab_o)
);

// File: tb/tb_din_cond_cell.sv
`timescale 1ns/1ps
module tb_din_cond_cell;

  logic       c0, c1, c2, c3;
  logic [3:0] sysclk;
  logic [3:0] sysclk_inv;
  logic [1:0] cap_sel;
  logic [1:0] cap_mode;
  logic       rst_ni, pad, pad_inv;
  logic       fab, gclk;
  logic       eff;
  int         nchk = 0;
  int         nerr = 0;

  assign sysclk = {c3, c2, c1, c0};
  assign eff    = sysclk[cap_sel] ^ sysclk_inv[cap_sel];

  initial begin c0 = 0; forever #4  c0 = ~c0; end  // 125 MHz
  initial begin c1 = 0; forever #8  c1 = ~c1; end
  initial begin c2 = 0; forever #12 c2 = ~c2; end
  initial begin c3 = 0; forever #20 c3 = ~c3; end

  din_cond_cell #(.NUM_SYSCLK(4), .IS_CLK_PIN(1'b1)) dut (
    .rst_ni       (rst_ni),
    .sysclk_i     (sysclk),
    .sysclk_inv_i (sysclk_inv),
    .cap_sel_i    (cap_sel),
    .cap_mode_i   (cap_mode),
    .pad_i        (pad),
    .pad_inv_i    (pad_inv),
    .fab_o        (fab),
    .gclk_o       (gclk)
  );

  // {mode[15:14], sel[13:12], inv[11], spare[10:8], pattern[7:0]}
  localparam logic [15:0] VEC [0:7] = '{
    16'h00B2, 16'h506D, 16'h68C5, 16'h8093,
    16'hB85A, 16'hD0A7, 16'hE836, 16'hC8F1
  };

  task automatic chk(input string req, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic setup(input logic [1:0] m, input logic [1:0] s, input logic inv);
    rst_ni     = 1'b0;
    pad        = 1'b0;
    cap_mode   = m;
    cap_sel    = s;
    sysclk_inv = '0;
    sysclk_inv[s] = inv;
    repeat (3) @(posedge c0);
    #2 rst_ni = 1'b1;
  endtask

  function automatic logic pbit(input logic [7:0] p, input int k);
    return (k < 0) ? 1'b0 : p[k];
  endfunction

  initial begin
    repeat (20000) @(posedge c0);
    nchk++; nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    rst_ni = 0; pad = 1; pad_inv = 0; cap_mode = 2'd3; cap_sel = 0; sysclk_inv = '0;
    repeat (3) @(posedge c0);
    #2 chk("R8 reg2 in reset", fab, 1'b0);
    cap_mode = 2'd1;
    repeat (2) @(posedge c0);
    #2 chk("R8 latch in reset", fab, 1'b0);
    cap_mode = 2'd0;
    #1 chk("R1 pass in reset", fab, 1'b1);
    pad = 0;
    #1 chk("R1 pass in reset low", fab, 1'b0);

    // R9 clock line polarity
    pad = 1; pad_inv = 0; #1 chk("R9 true", gclk, 1'b1);
    pad_inv = 1;          #1 chk("R9 inverted", gclk, 1'b0);
    pad = 0;              #1 chk("R9 inverted low", gclk, 1'b1);
    pad_inv = 0;

    for (int v = 0; v < 8; v++) begin
      logic [1:0] m;
      logic [7:0] p;
      string      lo_tag, hi_tag;
      logic       lo_e, hi_e;
      m = VEC[v][15:14];
      p = VEC[v][7:0];
      setup(m, VEC[v][13:12], VEC[v][11]);
      case (m)
        2'd0: begin lo_tag = "R1"; hi_tag = "R1"; end
        2'd1: begin lo_tag = "R2"; hi_tag = "R3"; end
        2'd2: begin lo_tag = "R4"; hi_tag = "R4"; end
        default: begin lo_tag = "R5"; hi_tag = "R5"; end
      endcase
      for (int i = 0; i < 8; i++) begin
        @(negedge eff);
        #1 pad = p[i];
        case (m)
          2'd0, 2'd1: lo_e = p[i];
          2'd2:       lo_e = pbit(p, i - 1);
          default:    lo_e = pbit(p, i - 2);
        endcase
        #1 chk($sformatf("%s R6 R7 vec%0d step%0d low", lo_tag, v, i), fab, lo_e);
        @(posedge eff);
        #1 pad = ~p[i];
        case (m)
          2'd0:       hi_e = ~p[i];
          2'd1, 2'd2: hi_e = p[i];
          default:    hi_e = pbit(p, i - 1);
        endcase
        #1 chk($sformatf("%s R6 R7 vec%0d step%0d high", hi_tag, v, i), fab, hi_e);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule